// File: doc/BRIEF.md
# Converter Sample to Lane Mapper

This block is the transport stage of a multi-lane serial converter link. Each cycle of the frame clock it can take one wide parallel word that holds two frames' worth of samples from eight converters. It regroups those samples into two lane words of octets. Each sample is 24 bits with no tail bits, so it maps to exactly three octets. Four converters share a lane, which makes a 12-octet frame per lane. One transfer therefore fills 24 octets, or 192 bits, on each lane.

The block raises its ready output one cycle after reset is released, and from then on it accepts every valid transfer. The user-data phase cannot be stalled, whatever the upstream valid does. One cycle after a transfer is taken, both lane words are presented together with a one-cycle valid pulse. Between pulses the lane words hold their last value. A synchronous reset ends the user-data phase and discards any word that has not yet been handed on.

Top module: `smpl_lane_mapper`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the following cycle shows `in_ready` = 0, `lane_valid` = 0 and `lane_data` = 0.
- R2: `in_ready` goes to 1 in the cycle after the first edge at which `rst` is sampled low. It then stays 1 on every cycle until reset is applied again, whatever `in_valid` does.
- R3: A transfer is taken at an edge where `in_valid` and `in_ready` are both 1. In the next cycle `lane_valid` is all ones for exactly one cycle. `lane_valid` is 0 in the cycle after any edge with no transfer.
- R4: Input layout: the sample of converter c (0..7) in frame f (0 = earlier frame, 1 = later) is `in_data[(f*8 + c)*24 +: 24]`.
- R5: Lane l occupies `lane_data[l*192 +: 192]`. Lane 0 carries converters 0 to 3 and lane 1 carries converters 4 to 7.
- R6: A lane word is 24 octets. Octet k (k = 0 is sent first) sits at bits `[191-8k -: 8]` of the lane word.
- R7: Within a lane word, frame 0 fills octets 0 to 11 and frame 1 fills octets 12 to 23. Within a frame, the lane's converters appear in ascending index order, three octets each, with the most significant octet of each sample first.
- R8: `lane_data` holds its value in every cycle that follows an edge with no transfer.
- R9: A reset applied during streaming discards the lane words already presented, so `lane_data` returns to 0. It also ends the user-data phase, and ready returns only under R2.
- R10: An `in_valid` that is high while `in_ready` is 0 (during reset and on the first edge after reset) is ignored. No valid pulse follows and `lane_data` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream transfer present |
| in_data | input | 384 | Two frames of samples from eight converters |
| in_ready | output | 1 | High while the user-data phase is active |
| lane_data | output | 384 | Two 192-bit lane words, lane 0 in the low half |
| lane_valid | output | 2 | One-cycle pulse per lane word |

## Verification
The bench sweeps a single set bit across all 384 input positions. A wrong octet order, a swapped lane or a misplaced frame therefore moves that bit to a position the arithmetic model does not predict. Tagged and random samples are streamed back to back to catch a valid that stretches past one cycle or drops out. Idle cycles with changing input data expose lane words that follow the input instead of holding. Valid is driven high during reset, during the release edge and again after a mid-stream reset. A design that took a transfer before the phase began, or that kept stale lane words across reset, would raise a valid pulse or show nonzero data at those points.

// File: rtl/smpl_map_pkg.sv
package smpl_map_pkg;

  // Bit index of the low bit of the input octet that becomes octet k
  // (k = 0 sent first) of lane 'lane'.
  function automatic int src_lsb(input int lane, input int k,
                                 input int conv_per_lane, input int num_conv,
                                 input int smpl_w);
    int oct_per_smpl;
    int frame_oct;
    int frm;
    int pos;
    int conv;
    int byt;
    oct_per_smpl = smpl_w / 8;
    frame_oct    = conv_per_lane * oct_per_smpl;
    frm          = k / frame_oct;
    pos          = k % frame_oct;
    conv         = lane * conv_per_lane + pos / oct_per_smpl;
    byt          = pos % oct_per_smpl;
    return (frm * num_conv + conv) * smpl_w + smpl_w - 8 - 8 * byt;
  endfunction

endpackage

// File: rtl/smpl_phase_ctrl.sv
module smpl_phase_ctrl (
  input  logic clk,
  input  logic rst,
  output logic user_phase,
  output logic phase_start_evt
);
  always_ff @(posedge clk) begin
    if (rst) user_phase <= 1'b0;
    else     user_phase <= 1'b1;
  end

  assign phase_start_evt = !rst && !user_phase;
endmodule

// File: rtl/smpl_lane_packer.sv
module smpl_lane_packer
  import smpl_map_pkg::*;
#(
  parameter int LANE_IDX      = 0,
  parameter int NUM_CONV      = 8,
  parameter int CONV_PER_LANE = 4,
  parameter int SMPL_W        = 24,
  parameter int IN_W          = 384,
  parameter int LANE_W        = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [IN_W-1:0]   in_data,
  output logic [LANE_W-1:0] lane_word,
  output logic              lane_vld
);
  localparam int OCT_PER_LANE = LANE_W / 8;

  logic [LANE_W-1:0] mapped;

  for (genvar k = 0; k < OCT_PER_LANE; k++) begin : g_oct
    localparam int SRC = src_lsb(LANE_IDX, k, CONV_PER_LANE, NUM_CONV, SMPL_W);
    assign mapped[LANE_W-8-8*k +: 8] = in_data[SRC +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_word <= '0;
      lane_vld  <= 1'b0;
    end else begin
      lane_vld <= accept;
      if (accept) lane_word <= mapped;
    end
  end
endmodule

// File: rtl/smpl_lane_mapper.sv
module smpl_lane_mapper #(
  parameter int NUM_CONV        = 8,
  parameter int NUM_LANES       = 2,
  parameter int SMPL_W          = 24,
  parameter int FRAMES_PER_XFER = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [NUM_CONV*SMPL_W*FRAMES_PER_XFER-1:0] in_data,
  output logic                             in_ready,
  output logic [NUM_CONV*SMPL_W*FRAMES_PER_XFER-1:0] lane_data,
  output logic [NUM_LANES-1:0]             lane_valid
);
  localparam int CONV_PER_LANE = NUM_CONV / NUM_LANES;
  localparam int IN_W          = NUM_CONV * SMPL_W * FRAMES_PER_XFER;
  localparam int LANE_W        = IN_W / NUM_LANES;

  logic user_phase;
  logic phase_start_evt;
  logic accept_evt;

  smpl_phase_ctrl u_phase (
    .clk             (clk),
    .rst             (rst),
    .user_phase      (user_phase),
    .phase_start_evt (phase_start_evt)
  );

  assign in_ready   = user_phase;
  assign accept_evt = in_valid && user_phase;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    smpl_lane_packer #(
      .LANE_IDX      (l),
      .NUM_CONV      (NUM_CONV),
      .CONV_PER_LANE (CONV_PER_LANE),
      .SMPL_W        (SMPL_W),
      .IN_W          (IN_W),
      .LANE_W        (LANE_W)
    ) u_pack (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept_evt),
      .in_data   (in_data),
      .lane_word (lane_data[l*LANE_W +: LANE_W]),
      .lane_vld  (lane_valid[l])
    );
  end
endmodule

// File: rtl/smpl_lane_mapper_chk.sv
module smpl_lane_mapper_chk #(
  parameter int NUM_LANES = 2,
  parameter int IN_W      = 384
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [IN_W-1:0]      lane_data,
  input logic [NUM_LANES-1:0] lane_valid,
  input logic                 accept_evt,
  input logic                 phase_start_evt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!in_ready && lane_valid == '0 && lane_data == '0));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    phase_start_evt |=> in_ready);

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

  // R3
  pulse_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (lane_valid == '1));

  // R3
  no_pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !accept_evt |=> (lane_valid == '0));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(lane_data));

  // R10
  no_take_early_chk: assert property (@(posedge clk) disable iff (rst)
    phase_start_evt |-> !accept_evt);
endmodule

bind smpl_lane_mapper smpl_lane_mapper_chk #(
  .NUM_LANES (NUM_LANES),
  .IN_W      (IN_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .lane_data       (lane_data),
  .lane_valid      (lane_valid),
  .accept_evt      (accept_evt),
  .phase_start_evt (phase_start_evt)
);

// File: tb/smpl_lane_mapper_bench.sv
module smpl_lane_mapper_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [383:0] in_data = '0;
  logic         in_ready;
  logic [383:0] lane_data;
  logic [1:0]   lane_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smpl_lane_mapper u_smpl_lane_mapper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_data(lane_data), .lane_valid(lane_valid)
  );

  // Reference: walk frames, converters, bytes in send order, shifting in.
  function automatic logic [383:0] model(input logic [383:0] d);
    logic [383:0] r;
    r = '0;
    for (int l = 0; l < 2; l++) begin
      logic [191:0] w;
      w = '0;
      for (int f = 0; f < 2; f++)
        for (int c = 0; c < 4; c++) begin
          logic [23:0] s;
          s = d[(f*8 + l*4 + c)*24 +: 24];
          for (int b = 0; b < 3; b++) w = {w[183:0], s[23-8*b -: 8]};
        end
      r[l*192 +: 192] = w;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  logic [383:0] held;

  initial begin
    // R1 / R10: reset with valid high and nonzero data
    in_valid = 1'b1;
    in_data  = {12{32'hDEADBEEF}};
    repeat (3) begin
      tick();
      chk(in_ready == 1'b0, "R1 ready", {383'd0, in_ready}, '0);
      chk(lane_valid == 2'b00, "R1 valid", {382'd0, lane_valid}, '0);
      chk(lane_data == '0, "R1 data", lane_data, '0);
    end
    rst = 1'b0;
    tick(); // first edge with rst low: phase starts, no take
    chk(in_ready == 1'b1, "R2 rise", {383'd0, in_ready}, 384'd1);
    chk(lane_valid == 2'b00, "R10 no early take", {382'd0, lane_valid}, '0);
    chk(lane_data == '0, "R10 data untouched", lane_data, '0);

    // R4 R5 R6 R7: walking one over every input bit, back to back
    for (int i = 0; i < 384; i++) begin
      in_data = '0;
      in_data[i] = 1'b1;
      tick();
      chk(lane_valid == 2'b11, "R3 pulse", {382'd0, lane_valid}, 384'd3);
      chk(lane_data == model(in_data), "R7 walk", lane_data, model(in_data));
    end

    // R5 R7: tagged samples, frame and converter in the sample value
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 8; c++)
        in_data[(f*8 + c)*24 +: 24] = 24'hA00000 | 24'(f << 12) | 24'(c << 4) | 24'(c + 1);
    tick();
    chk(lane_data == model(in_data), "R5 tagged", lane_data, model(in_data));

    // R8 / R2: idle with changing data
    held = lane_data;
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_data = {12{$urandom()}};
      tick();
      chk(lane_valid == 2'b00, "R3 idle", {382'd0, lane_valid}, '0);
      chk(lane_data == held, "R8 hold", lane_data, held);
      chk(in_ready == 1'b1, "R2 stays", {383'd0, in_ready}, 384'd1);
    end

    // R3: random streaming with gaps
    for (int i = 0; i < 40; i++) begin
      logic [383:0] exp;
      for (int w = 0; w < 12; w++) in_data[w*32 +: 32] = $urandom();
      in_valid = (i % 3) != 2;
      exp = in_valid ? model(in_data) : lane_data;
      tick();
      chk(lane_valid == (in_valid ? 2'b11 : 2'b00), "R3 stream",
          {382'd0, lane_valid}, in_valid ? 384'd3 : 384'd0);
      chk(lane_data == exp, "R6 stream", lane_data, exp);
    end

    // R9: reset mid-stream
    in_valid = 1'b1;
    rst = 1'b1;
    tick();
    chk(in_ready == 1'b0, "R9 ready", {383'd0, in_ready}, '0);
    chk(lane_data == '0, "R9 data", lane_data, '0);
    chk(lane_valid == 2'b00, "R9 valid", {382'd0, lane_valid}, '0);
    rst = 1'b0;
    tick();
    chk(in_ready == 1'b1, "R9 ready back", {383'd0, in_ready}, 384'd1);
    chk(lane_valid == 2'b00, "R10 after reset", {382'd0, lane_valid}, '0);
    tick();
    chk(lane_data == model(in_data), "R9 first take", lane_data, model(in_data));
    in_valid = 1'b0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule